// File: doc/BRIEF.md
# Right-justified TDM audio serial transmitter

This block takes left and right audio samples as parallel words and sends them, one bit per bit clock, on a serial data line that it can share with other transmitters. The bit clock and the word clock come from an external master and are sampled by the block's system clock, which must run at least four times faster than the bit clock. A word-clock rising edge opens a frame. The high half of the word clock carries the left sample and the low half carries the right sample. Each sample is right-justified, so its LSB is the last bit before the word clock changes level.

A programmable slot offset moves the slot earlier within each half by a whole number of bit clocks. Several transmitters with different offsets can then take turns on one line. Outside its own bits the block lowers its output enable, so the pad that this enable drives floats the line.

Samples arrive on a valid/ready interface that has one holding entry. Back-pressure works as follows. `s_ready` is high only while the holding entry is empty. A sample moves across on a clock edge where `s_valid` and `s_ready` are both high. The source must keep `s_valid` and the data steady until that edge. The held sample becomes the transmitted sample at the next enabled frame start, and `s_consumed` reports that move.

Top module: `tdm_rj_tx`

## Requirements
- R1: Bit positions p in a half count from 0, which is the first bit clock after a word-clock change, up to HALF_BITS-1. With slot offset 0, the sample LSB is sent at position HALF_BITS-1, the last rising bit-clock edge before the word clock changes level. The left LSB comes before the word clock falls and the right LSB before it rises.
- R2: For a width of W bits and a slot offset of O, the slot covers positions HALF_BITS-W-O up to HALF_BITS-1-O. At position p inside the slot the line carries sample bit HALF_BITS-1-O-p, which sends the data MSB first. The left sample goes out while the word clock is high and the right sample while it is low.
- R3: If W+O is greater than HALF_BITS, that frame drives nothing in either half.
- R4: The 2-bit width select chooses the width: code 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. A narrower width sends the low-order W bits of the input word.
- R5: Outside the slot, `sdata_oe` is low and `sdata` is 0. Both outputs change only after a falling edge of the bit clock, so they are steady at each rising edge.
- R6: After reset, `sdata_oe` stays low until the first word-clock rising edge, which is seen at a bit-clock falling edge.
- R7: Enable, width and offset are captured at each frame start. Changing them in the middle of a frame has no effect on that frame.
- R8: If enable is low at a frame start, `sdata_oe` stays low for that whole frame and the held sample stays in the holding entry.
- R9: `s_ready` is high exactly when the one-entry holding register is empty. After a transfer, `s_ready` is low on the next cycle.
- R10: At an enabled frame start with a held sample, that sample becomes the transmitted sample for the frame. `s_consumed` is then high for one system-clock cycle and `s_ready` returns high.
- R11: If no sample is held at a frame start, the previous sample pair is sent again. After reset that pair is all zeros.
- R12: A transfer on the same clock edge as a frame start does not change that frame. The transferred sample is sent in the next frame.
- R13: While and after reset, before any bit-clock activity: `sdata_oe`=0, `sdata`=0, `s_ready`=1 and `s_consumed`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both serial clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock from the master |
| wclk | input | 1 | Word clock from the master; high means left half |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding entry empty |
| s_left | input | SAMPLE_W | Left sample; the low bits are used for narrow widths |
| s_right | input | SAMPLE_W | Right sample |
| enable | input | 1 | Transmit enable, captured at frame start |
| width_sel | input | 2 | Width code (0:16, 1:20, 2:24, 3:32) |
| slot_off | input | $clog2(HALF_BITS) | Slot offset in bit clocks |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Drive enable for the shared data line |
| s_consumed | output | 1 | One-cycle pulse when a held sample is put into use |

## Verification
Two functions can fall in the same cycle. A new sample can be accepted into the holding entry on the same edge where a frame start decides whether to use the held sample. The bench raises `s_valid` on the same system-clock edge that sees the bit clock fall together with the word-clock rise. It then expects the previous pair to repeat bit for bit in that frame and the new pair to appear one frame later. Around this case, sweeps over every width code and six offsets compare each bit-clock slot of every frame against arithmetic slot bounds. The sweeps include offsets that overflow the half and frames where enable is low.

// File: rtl/tdm_rj_pkg.sv
package tdm_rj_pkg;
  typedef enum logic [1:0] {
    WID_16 = 2'd0,
    WID_20 = 2'd1,
    WID_24 = 2'd2,
    WID_32 = 2'd3
  } wid_code_e;

  function automatic int unsigned wid_bits(input wid_code_e c);
    case (c)
      WID_16:  return 16;
      WID_20:  return 20;
      WID_24:  return 24;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          wclk,
  output logic          tick,
  output logic          frame_start,
  output logic          left_now,
  output logic          synced_now,
  output logic [PW-1:0] pos_now
);
  logic          bclk_q;
  logic          wclk_last;
  logic          synced_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_inc;
  logic          half_edge;

  assign tick        = bclk_q & ~bclk;
  assign half_edge   = wclk ^ wclk_last;
  assign frame_start = tick & wclk & ~wclk_last;
  assign pos_inc     = (&pos_q) ? pos_q : pos_q + 1'b1;
  assign pos_now     = half_edge ? '0 : pos_inc;
  assign left_now    = wclk;
  assign synced_now  = synced_q | frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      wclk_last <= 1'b1;
      synced_q  <= 1'b0;
      pos_q     <= '0;
    end else begin
      bclk_q <= bclk;
      if (tick) begin
        wclk_last <= wclk;
        pos_q     <= pos_now;
        synced_q  <= synced_now;
      end
    end
  end

  assert_sync_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> synced_q);

  assert_pos_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (wclk != wclk_last)) |=> (pos_q == '0));
endmodule

// File: rtl/tdm_sample_stage.sv
module tdm_sample_stage
  import tdm_rj_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int OFF_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                frame_start,
  input  logic                enable,
  input  logic [1:0]          width_sel,
  input  logic [OFF_W-1:0]    slot_off,
  output logic                consumed,
  output logic                frame_en,
  output logic                en_now,
  output wid_code_e           wid_now,
  output logic [OFF_W-1:0]    off_now,
  output logic [SAMPLE_W-1:0] left_now,
  output logic [SAMPLE_W-1:0] right_now
);
  logic                hold_full;
  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic [SAMPLE_W-1:0] act_l, act_r;
  wid_code_e           wid_q;
  logic [OFF_W-1:0]    off_q;
  logic                accept, take;

  assign s_ready = ~hold_full;
  assign accept  = s_valid & s_ready;
  assign take    = frame_start & enable & hold_full;

  assign en_now    = frame_start ? enable : frame_en;
  assign wid_now   = frame_start ? wid_code_e'(width_sel) : wid_q;
  assign off_now   = frame_start ? slot_off : off_q;
  assign left_now  = take ? hold_l : act_l;
  assign right_now = take ? hold_r : act_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      act_l     <= '0;
      act_r     <= '0;
      frame_en  <= 1'b0;
      wid_q     <= WID_16;
      off_q     <= '0;
      consumed  <= 1'b0;
    end else begin
      consumed <= take;
      if (accept) begin
        hold_full <= 1'b1;
        hold_l    <= s_left;
        hold_r    <= s_right;
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (take) begin
        act_l <= hold_l;
        act_r <= hold_r;
      end
      if (frame_start) begin
        frame_en <= enable;
        wid_q    <= wid_code_e'(width_sel);
        off_q    <= slot_off;
      end
    end
  end

  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  assert_consume_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    consumed |-> s_ready);
endmodule

// File: rtl/tdm_slot_shifter.sv
module tdm_slot_shifter
  import tdm_rj_pkg::*;
#(
  parameter int SAMPLE_W  = 32,
  parameter int HALF_BITS = 64,
  parameter int PW        = 7,
  parameter int OFF_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [PW-1:0]       pos_now,
  input  logic                left_now,
  input  logic                synced_now,
  input  logic                en_now,
  input  wid_code_e           wid_now,
  input  logic [OFF_W-1:0]    off_now,
  input  logic [SAMPLE_W-1:0] left_data,
  input  logic [SAMPLE_W-1:0] right_data,
  output logic                sd,
  output logic                oe
);
  localparam int CW = $clog2(HALF_BITS + SAMPLE_W + 1) + 1;

  logic [CW-1:0]       w_c, off_c, pos_c, start_c, stop_c, idx_c;
  logic                fits, in_slot, bit_v;
  logic [SAMPLE_W-1:0] cur;

  always_comb begin
    w_c     = CW'(wid_bits(wid_now));
    off_c   = CW'(off_now);
    pos_c   = CW'(pos_now);
    fits    = (w_c + off_c) <= CW'(HALF_BITS);
    stop_c  = CW'(HALF_BITS) - off_c;
    start_c = stop_c - w_c;
    in_slot = fits && (pos_c >= start_c) && (pos_c < stop_c);
    idx_c   = stop_c - CW'(1) - pos_c;
    cur     = left_now ? left_data : right_data;
  end

  always_comb begin
    bit_v = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (idx_c == CW'(i)) bit_v = cur[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd <= 1'b0;
      oe <= 1'b0;
    end else if (tick) begin
      oe <= synced_now & en_now & in_slot;
      sd <= synced_now & en_now & in_slot & bit_v;
    end
  end

  assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(oe) && $stable(sd)));
endmodule

// File: rtl/tdm_rj_tx.sv
module tdm_rj_tx
  import tdm_rj_pkg::*;
#(
  parameter int SAMPLE_W  = 32,
  parameter int HALF_BITS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bclk,
  input  logic                         wclk,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [SAMPLE_W-1:0]          s_left,
  input  logic [SAMPLE_W-1:0]          s_right,
  input  logic                         enable,
  input  logic [1:0]                   width_sel,
  input  logic [$clog2(HALF_BITS)-1:0] slot_off,
  output logic                         sdata,
  output logic                         sdata_oe,
  output logic                         s_consumed
);
  localparam int OFF_W = $clog2(HALF_BITS);
  localparam int PW    = $clog2(HALF_BITS) + 1;

  logic                tick, frame_start, left_now, synced_now;
  logic [PW-1:0]       pos_now;
  logic                frame_en, en_now;
  wid_code_e           wid_now;
  logic [OFF_W-1:0]    off_now;
  logic [SAMPLE_W-1:0] left_data, right_data;

  tdm_bit_timer #(.PW(PW)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk        (bclk),
    .wclk        (wclk),
    .tick        (tick),
    .frame_start (frame_start),
    .left_now    (left_now),
    .synced_now  (synced_now),
    .pos_now     (pos_now)
  );

  tdm_sample_stage #(.SAMPLE_W(SAMPLE_W), .OFF_W(OFF_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .s_left      (s_left),
    .s_right     (s_right),
    .frame_start (frame_start),
    .enable      (enable),
    .width_sel   (width_sel),
    .slot_off    (slot_off),
    .consumed    (s_consumed),
    .frame_en    (frame_en),
    .en_now      (en_now),
    .wid_now     (wid_now),
    .off_now     (off_now),
    .left_now    (left_data),
    .right_now   (right_data)
  );

  tdm_slot_shifter #(
    .SAMPLE_W  (SAMPLE_W),
    .HALF_BITS (HALF_BITS),
    .PW        (PW),
    .OFF_W     (OFF_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pos_now    (pos_now),
    .left_now   (left_now),
    .synced_now (synced_now),
    .en_now     (en_now),
    .wid_now    (wid_now),
    .off_now    (off_now),
    .left_data  (left_data),
    .right_data (right_data),
    .sd         (sdata),
    .oe         (sdata_oe)
  );

  assert_drive_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> frame_en);
endmodule

// File: tb/sim_tdm_rj_tx.sv
`timescale 1ns/1ps
module sim_tdm_rj_tx;
  localparam int HB = 64;
  localparam int SW = 32;
  localparam int OW = $clog2(HB);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0, bclk = 1'b0, wclk = 1'b0;
  logic          s_valid = 1'b0, s_ready, enable = 1'b0;
  logic [SW-1:0] s_left = '0, s_right = '0;
  logic [1:0]    width_sel = '0;
  logic [OW-1:0] slot_off = '0;
  logic          sdata, sdata_oe, s_consumed;

  tdm_rj_tx #(.SAMPLE_W(SW), .HALF_BITS(HB)) u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .enable(enable), .width_sel(width_sel), .slot_off(slot_off),
    .sdata(sdata), .sdata_oe(sdata_oe), .s_consumed(s_consumed)
  );

  int checks = 0, fails = 0, cons_seen = 0, exp_cons = 0;
  int offs[6] = '{0, 1, 5, 16, 32, 33};

  bit            m_sync = 0, m_en = 0, m_full = 0;
  int            m_w = 16, m_off = 0;
  logic [SW-1:0] m_l = '0, m_r = '0, m_bl = '0, m_br = '0;

  always @(posedge clk) if (rst_n && s_consumed) cons_seen++;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int wbits(input int c);
    case (c)
      0: return 16;
      1: return 20;
      2: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic set_cfg(input int f);
    if (f < 48) begin
      enable = 1'b1; width_sel = 2'(f / 12); slot_off = OW'(offs[(f / 2) % 6]);
    end else begin
      enable = (f != 48); width_sel = 2'd1; slot_off = OW'(1);
    end
  endtask

  task automatic bit_step(input logic w, input int p, input int f, input bit push, input bit start);
    string tag;
    int start_p, stop_p;
    logic [SW-1:0] cur;
    logic exp_oe, exp_sd;
    @(negedge clk);
    bclk = 1'b0; wclk = w;
    if (start) begin
      m_sync = 1; m_en = enable; m_w = wbits(int'(width_sel)); m_off = int'(slot_off);
      if (enable && m_full) begin
        m_l = m_bl; m_r = m_br; m_full = 0; exp_cons++;
      end
    end
    if (push) begin
      chk("R9", "s_ready before offer", 64'(s_ready), 64'(!m_full));
      s_valid = 1'b1;
      s_left  = 32'h9E37_79B9 * 32'(f + 1);
      s_right = 32'h7F4A_7C15 ^ (32'h0101_0101 * 32'(f + 3));
      m_bl = s_left; m_br = s_right; m_full = 1;
    end
    @(negedge clk);
    if (push) begin
      s_valid = 1'b0;
      chk("R9", "s_ready after transfer", 64'(s_ready), 64'd0);
    end
    @(negedge clk);
    bclk = 1'b1;
    cur = w ? m_l : m_r;
    stop_p = HB - m_off;
    start_p = stop_p - m_w;
    exp_oe = 0;
    exp_sd = 0;
    if (!m_sync) tag = "R6";
    else if (!m_en) tag = "R8";
    else if (m_w + m_off > HB) tag = "R3";
    else if (p >= start_p && p < stop_p) begin
      exp_oe = 1;
      exp_sd = cur[stop_p - 1 - p];
      if (p == stop_p - 1) tag = "R1";
      else if (p == start_p) tag = "R4";
      else if (!w && p > HB / 2 && f < 51) tag = "R7";
      else if (f == 50) tag = "R12";
      else if (f < 48 && f % 2 == 1) tag = "R11";
      else tag = "R2";
    end else tag = "R5";
    chk(tag, $sformatf("oe f%0d %s p%0d", f, w ? "L" : "R", p), 64'(sdata_oe), 64'(exp_oe));
    chk(tag, $sformatf("sd f%0d %s p%0d", f, w ? "L" : "R", p), 64'(sdata), 64'(exp_sd));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R13", "oe in reset", 64'(sdata_oe), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13", "oe after reset", 64'(sdata_oe), 64'd0);
    chk("R13", "sd after reset", 64'(sdata), 64'd0);
    chk("R13", "ready after reset", 64'(s_ready), 64'd1);
    chk("R13", "consumed after reset", 64'(s_consumed), 64'd0);
    set_cfg(0);
    for (int p = 0; p < 10; p++) bit_step(1'b0, p, -1, 1'b0, 1'b0);
    for (int f = 0; f < 52; f++) begin
      for (int p = 0; p < HB; p++)
        bit_step(1'b1, p, f,
                 (f == 50 && p == 0) || (p == HB / 4 && f != 50 && (f == 48 || (f < 48 && f % 2 == 0))),
                 p == 0);
      for (int p = 0; p < HB; p++) begin
        if (p == HB / 2 && f < 51) set_cfg(f + 1);
        bit_step(1'b0, p, f, 1'b0, 1'b0);
      end
      chk("R10", $sformatf("consumed pulses after frame %0d", f), 64'(cons_seen), 64'(exp_cons));
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule